// File: doc/BRIEF.md
# Maskable GPIO Port Controller

This block controls one parallel I/O port of `DATA_W` pins (32 by default) through a small register window. Software reaches the registers over a simple synchronous bus with byte enables. The block drives every pin through its own output enable. Each pin is switched between input and output by a direction bit. The output levels are held in an output register, which software can rewrite as a whole or change bit by bit.

Two write-only registers change only the bits written as one. One of them raises those output bits and the other lowers them, so software needs no read-modify-write sequence. A mask register marks a group of pins as protected. Protected bits keep their output value through every kind of port write, and they read as zero from the pin register. Software can therefore update a field of the port without touching its neighbours.

Pin levels pass through a two-stage synchronizer before software can read them. The output register and the synchronized pin levels are read at different offsets.

Top module: `gpio_mask_port`

## Requirements
- R1: When `rst` is high at a rising edge, the direction, output and mask registers, `pin_oe`, `pin_o` and `bus_rdata` are all zero after that edge. All pins therefore start as inputs.
- R2: The direction register sits at word offset 0. `pin_oe[i]` equals direction bit i: 1 drives the pin as an output and 0 leaves it an input. `pin_o` always shows the output register.
- R3: A write to offset 1 (output register) or to offset 5 (pin register) loads the write data into every enabled, unmasked bit of the output register. A read of offset 1 returns the output register, whatever the pin levels are.
- R4: A write to offset 2 (set) makes 1 every enabled, unmasked output bit written as 1, and leaves every other bit unchanged. A read of offset 2 returns zero.
- R5: A write to offset 3 (clear) makes 0 every enabled, unmasked output bit written as 1, and leaves every other bit unchanged. A read of offset 3 returns zero.
- R6: The mask register sits at offset 4 and reads back as written. An output bit whose mask bit is 1 is not changed by writes to offsets 1, 2, 3 or 5.
- R7: A read of offset 5 returns the pin levels as they stood two rising edges before the read edge, with every masked bit read as 0.
- R8: `bus_be[k]` enables byte k (bits 8k+7 down to 8k) of every register write. Bits in disabled bytes keep their value.
- R9: Offsets 6 and 7 read as zero. Writes to them, and cycles with no write, change no register.
- R10: Read data appears on `bus_rdata` just after the rising edge that accepts the read. It holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access request for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Word offset of the register |
| bus_be | input | DATA_W/8 | Byte enables for writes |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| pin_i | input | DATA_W | Raw pin levels |
| pin_o | output | DATA_W | Output levels |
| pin_oe | output | DATA_W | Per-pin output enable |

## Verification
Directed patterns run first. All-ones and all-zeros words, alternating bit patterns and single-byte enables show whether set, clear and full writes keep their own semantics. They also show whether each byte lane is gated on its own. Pin levels that differ from the output register tell the two read offsets apart. A mask covering half of the port shows whether each write path respects protection. After that, a long run of random accesses at random offsets, with random byte enables, random data and random pin changes, is compared against a register model in the bench. This exposes interactions between the mask, the lanes and the write kinds.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    localparam int GP_ADDR_W = 3;

    typedef enum logic [GP_ADDR_W-1:0] {
        OFS_DIR  = 3'd0,
        OFS_OUT  = 3'd1,
        OFS_SET  = 3'd2,
        OFS_CLR  = 3'd3,
        OFS_MASK = 3'd4,
        OFS_PIN  = 3'd5
    } gp_ofs_e;

    // one strobe per kind of register update
    typedef struct packed {
        logic dir;
        logic out;
        logic set;
        logic clr;
        logic mask;
    } gp_wstb_t;

    // read request carried from decode to the read mux
    typedef struct packed {
        logic    en;
        gp_ofs_e ofs;
        logic    mapped;
    } gp_rreq_t;

    function automatic logic is_mapped(input logic [GP_ADDR_W-1:0] a);
        return a <= 3'd5;
    endfunction

endpackage

// File: rtl/gpio_bus_decode.sv
module gpio_bus_decode
    import gpio_port_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int BE_W  = DATA_W / 8
) (
    input  logic                 bus_sel,
    input  logic                 bus_wr,
    input  logic [GP_ADDR_W-1:0] bus_addr,
    input  logic [BE_W-1:0]      bus_be,
    output gp_wstb_t             wstb,
    output gp_rreq_t             rreq,
    output logic [DATA_W-1:0]    bmask
);

    gp_ofs_e ofs;
    logic    wr_go;

    assign ofs   = gp_ofs_e'(bus_addr);
    assign wr_go = bus_sel && bus_wr;

    // widen each byte enable over its eight bits
    for (genvar b = 0; b < BE_W; b++) begin : g_lane
        assign bmask[b*8 +: 8] = {8{bus_be[b]}};
    end

    always_comb begin
        wstb = '0;
        if (wr_go) begin
            case (ofs)
                OFS_DIR:          wstb.dir  = 1'b1;
                OFS_OUT, OFS_PIN: wstb.out  = 1'b1;
                OFS_SET:          wstb.set  = 1'b1;
                OFS_CLR:          wstb.clr  = 1'b1;
                OFS_MASK:         wstb.mask = 1'b1;
                default:          wstb      = '0;
            endcase
        end
    end

    always_comb begin
        rreq.en     = bus_sel && !bus_wr;
        rreq.ofs    = ofs;
        rreq.mapped = is_mapped(bus_addr);
    end

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) chain[0] <= '0;
        else     chain[0] <= d;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) chain[s] <= '0;
            else     chain[s] <= chain[s-1];
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
    import gpio_port_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  gp_wstb_t          wstb,
    input  logic [DATA_W-1:0] bmask,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] dir_q,
    output logic [DATA_W-1:0] out_q,
    output logic [DATA_W-1:0] mask_q
);

    logic [DATA_W-1:0] open_bits;   // enabled and not protected
    logic [DATA_W-1:0] hi_bits;
    logic [DATA_W-1:0] lo_bits;
    logic [DATA_W-1:0] out_d;

    assign open_bits = bmask & ~mask_q;
    assign hi_bits   = wstb.set ? (wdata & open_bits) : '0;
    assign lo_bits   = wstb.clr ? (wdata & open_bits) : '0;

    always_comb begin
        out_d = out_q;
        if (wstb.out) out_d = (out_q & ~open_bits) | (wdata & open_bits);
        out_d = out_d | hi_bits;
        out_d = out_d & ~lo_bits;   // lowering wins on overlap
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q  <= '0;
            out_q  <= '0;
            mask_q <= '0;
        end else begin
            out_q <= out_d;
            if (wstb.dir)  dir_q  <= (dir_q  & ~bmask) | (wdata & bmask);
            if (wstb.mask) mask_q <= (mask_q & ~bmask) | (wdata & bmask);
        end
    end

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (dir_q == '0 && out_q == '0 && mask_q == '0)); // R1

    AST_SET_RAISES: assert property (@(posedge clk) disable iff (rst)
        wstb.set |=> ((out_q & $past(wdata & bmask & ~mask_q)) == $past(wdata & bmask & ~mask_q))); // R4

    AST_CLR_LOWERS: assert property (@(posedge clk) disable iff (rst)
        wstb.clr |=> ((out_q & $past(wdata & bmask & ~mask_q)) == '0)); // R5

    AST_MASK_GUARD: assert property (@(posedge clk) disable iff (rst)
        (wstb.out || wstb.set || wstb.clr) |=> ((out_q & $past(mask_q)) == $past(out_q & mask_q))); // R6

    AST_LANE_KEEP: assert property (@(posedge clk) disable iff (rst)
        wstb.dir |=> ((dir_q & ~$past(bmask)) == ($past(dir_q) & ~$past(bmask)))); // R8

    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
        (wstb == '0) |=> ($stable(dir_q) && $stable(out_q) && $stable(mask_q))); // R9

endmodule

// File: rtl/gpio_mask_port.sv
module gpio_mask_port
    import gpio_port_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int SYNC_STAGES = 2,
    localparam int BE_W       = DATA_W / 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_sel,
    input  logic                 bus_wr,
    input  logic [GP_ADDR_W-1:0] bus_addr,
    input  logic [BE_W-1:0]      bus_be,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    input  logic [DATA_W-1:0]    pin_i,
    output logic [DATA_W-1:0]    pin_o,
    output logic [DATA_W-1:0]    pin_oe
);

    gp_wstb_t          wstb;
    gp_rreq_t          rreq;
    logic [DATA_W-1:0] bmask;
    logic [DATA_W-1:0] dir_q;
    logic [DATA_W-1:0] out_q;
    logic [DATA_W-1:0] mask_q;
    logic [DATA_W-1:0] pin_s;
    logic [DATA_W-1:0] rd_mux;
    logic [DATA_W-1:0] rdata_q;

    gpio_bus_decode #(.DATA_W(DATA_W)) u_dec (
        .bus_sel (bus_sel),
        .bus_wr  (bus_wr),
        .bus_addr(bus_addr),
        .bus_be  (bus_be),
        .wstb    (wstb),
        .rreq    (rreq),
        .bmask   (bmask)
    );

    gpio_port_regs #(.DATA_W(DATA_W)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .wstb  (wstb),
        .bmask (bmask),
        .wdata (bus_wdata),
        .dir_q (dir_q),
        .out_q (out_q),
        .mask_q(mask_q)
    );

    gpio_in_sync #(.WIDTH(DATA_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk),
        .rst(rst),
        .d  (pin_i),
        .q  (pin_s)
    );

    always_comb begin
        rd_mux = '0;
        if (rreq.mapped) begin
            case (rreq.ofs)
                OFS_DIR:  rd_mux = dir_q;
                OFS_OUT:  rd_mux = out_q;
                OFS_MASK: rd_mux = mask_q;
                OFS_PIN:  rd_mux = pin_s & ~mask_q;
                default:  rd_mux = '0;   // set / clear are write-only
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)          rdata_q <= '0;
        else if (rreq.en) rdata_q <= rd_mux;
    end

    assign bus_rdata = rdata_q;
    assign pin_o     = out_q;
    assign pin_oe    = dir_q;

    AST_PIN_MASKED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rreq.en && rreq.ofs == OFS_PIN) |=> ((bus_rdata & $past(mask_q)) == '0)); // R7

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        !rreq.en |=> $stable(bus_rdata)); // R10

    AST_WO_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rreq.en && (rreq.ofs == OFS_SET || rreq.ofs == OFS_CLR || !rreq.mapped)) |=> (bus_rdata == '0)); // R4

endmodule

// File: tb/gpio_mask_port_test.sv
module gpio_mask_port_test;

    localparam int W  = 32;
    localparam int BW = W / 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_sel = 1'b0;
    logic          bus_wr = 1'b0;
    logic [2:0]    bus_addr = '0;
    logic [BW-1:0] bus_be = '0;
    logic [W-1:0]  bus_wdata = '0;
    logic [W-1:0]  bus_rdata;
    logic [W-1:0]  pin_i = '0;
    logic [W-1:0]  pin_o;
    logic [W-1:0]  pin_oe;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    logic [W-1:0] m_dir = '0, m_out = '0, m_mask = '0, m_pin = '0;

    always #5 clk = ~clk;

    gpio_mask_port #(.DATA_W(W)) uut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .pin_i(pin_i), .pin_o(pin_o), .pin_oe(pin_oe)
    );

    function automatic logic [W-1:0] lanes(input logic [BW-1:0] be);
        logic [W-1:0] r = '0;
        for (int k = 0; k < W; k++) r[k] = be[k/8];
        return r;
    endfunction

    // model of one write, from the requirements
    function automatic void model_wr(input logic [2:0] a, input logic [BW-1:0] be,
                                     input logic [W-1:0] d);
        logic [W-1:0] en = lanes(be);
        logic [W-1:0] op = en & ~m_mask;
        case (a)
            3'd0: m_dir  = (m_dir & ~en) | (d & en);
            3'd1, 3'd5: m_out = (m_out & ~op) | (d & op);
            3'd2: m_out  = m_out | (d & op);
            3'd3: m_out  = m_out & ~(d & op);
            3'd4: m_mask = (m_mask & ~en) | (d & en);
            default: ;
        endcase
    endfunction

    function automatic logic [W-1:0] model_rd(input logic [2:0] a);
        case (a)
            3'd0: return m_dir;
            3'd1: return m_out;
            3'd4: return m_mask;
            3'd5: return m_pin & ~m_mask;
            default: return '0;
        endcase
    endfunction

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [BW-1:0] be, input logic [W-1:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_be = be; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        model_wr(a, be, d);
    endtask

    task automatic rd(input logic [2:0] a, output logic [W-1:0] v);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
        v = bus_rdata;
    endtask

    task automatic rd_chk(input string tag, input logic [2:0] a);
        logic [W-1:0] v;
        rd(a, v);
        check(tag, v, model_rd(a));
    endtask

    task automatic drive_pins(input logic [W-1:0] v);
        pin_i = v; m_pin = v;
        repeat (2) @(negedge clk);
    endtask

    task automatic port_chk(input string tag);
        check({tag, " pin_oe"}, pin_oe, m_dir);
        check({tag, " pin_o"},  pin_o,  m_out);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : stim
        logic [W-1:0] v, held;
        void'($urandom(32'h5EED_0123));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check("R1 pin_oe", pin_oe, '0);
        check("R1 pin_o", pin_o, '0);
        check("R1 rdata", bus_rdata, '0);
        rd_chk("R1 mask read", 3'd4);

        // R2 direction drives output enables
        wr(3'd0, 4'hF, 32'hA5A5_0F0F);
        port_chk("R2");
        rd_chk("R2 dir read", 3'd0);

        // R3 full write, pins differ from output register
        drive_pins(32'h1234_5678);
        wr(3'd1, 4'hF, 32'hFFFF_0000);
        port_chk("R3");
        rd_chk("R3 out read", 3'd1);
        rd_chk("R7 pin read", 3'd5);
        wr(3'd5, 4'hF, 32'h0000_FFFF);
        rd_chk("R3 write via pin offset", 3'd1);

        // R4 set / R5 clear
        wr(3'd2, 4'hF, 32'h00F0_0000);
        port_chk("R4");
        rd_chk("R4 set reads zero", 3'd2);
        wr(3'd3, 4'hF, 32'h0000_0F0F);
        port_chk("R5");
        rd_chk("R5 clr reads zero", 3'd3);

        // R6 mask protects upper half from all write kinds
        wr(3'd4, 4'hF, 32'hFFFF_0000);
        rd_chk("R6 mask read", 3'd4);
        wr(3'd1, 4'hF, 32'h5555_5555);
        wr(3'd2, 4'hF, 32'hFFFF_FFFF);
        wr(3'd3, 4'hF, 32'hAAAA_0000);
        wr(3'd5, 4'hF, 32'h0F0F_0F0F);
        port_chk("R6");
        rd_chk("R6 out after masked writes", 3'd1);
        rd_chk("R7 masked pin read", 3'd5);
        drive_pins(32'hFFFF_FFFF);
        rd_chk("R7 pin all ones masked", 3'd5);

        // R8 byte lanes
        wr(3'd4, 4'h0, 32'hFFFF_FFFF);
        rd_chk("R8 mask no lanes", 3'd4);
        wr(3'd4, 4'h4, 32'h0000_0000);
        rd_chk("R8 mask lane2", 3'd4);
        wr(3'd0, 4'h1, 32'hFFFF_FFFF);
        port_chk("R8 dir lane0");
        wr(3'd2, 4'h2, 32'hFFFF_FFFF);
        port_chk("R8 set lane1");

        // R9 unmapped offsets
        wr(3'd6, 4'hF, 32'hDEAD_BEEF);
        wr(3'd7, 4'hF, 32'h0000_0000);
        port_chk("R9");
        rd_chk("R9 mask unchanged", 3'd4);
        rd_chk("R9 read 6", 3'd6);
        rd_chk("R9 read 7", 3'd7);

        // R10 read latency and hold
        rd(3'd0, held);
        check("R10 latency", held, m_dir);
        wr(3'd1, 4'hF, 32'h1111_2222);
        repeat (3) @(negedge clk);
        check("R10 hold", bus_rdata, held);

        // random phase against the model
        for (int i = 0; i < 600; i++) begin
            logic [2:0] a = 3'($urandom_range(0, 7));
            int op = $urandom_range(0, 9);
            if (op < 5) begin
                wr(a, 4'($urandom), $urandom);
                port_chk("R3 R4 R5 R6 R8 random");
            end else if (op < 9) begin
                rd_chk("R7 R9 R10 random read", a);
            end else begin
                drive_pins($urandom);
                rd_chk("R7 random pins", 3'd5);
            end
        end

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule